// File: doc/BRIEF.md
# LCD Horizontal Line Timer

This block produces the horizontal timing of a raster LCD panel, one line after another. It runs on the system clock and divides it into a panel clock. Each line passes through a sync pulse, a back porch, an active data window and a front porch, and then a short line-end strobe. The block drives the horizontal sync, the panel clock, a data-enable window, the number of panel clocks in the active window, and the line-end strobe. Vertical timing, pixel fetch and the colour path belong to other blocks.

The line sequencer is a state machine with six states. `ST_IDLE` lasts one cycle after reset, samples the configuration, and moves to `ST_SYNC`. `ST_SYNC` moves to `ST_BPORCH`, `ST_BPORCH` to `ST_ACTIVE`, `ST_ACTIVE` to `ST_FPORCH`, and `ST_FPORCH` to `ST_LEND`. Each of these four steps is taken on the panel-clock tick in which the region counter is at zero. `ST_LEND` returns to `ST_SYNC` after a fixed number of system clocks. The configuration is sampled again on that transition.

The active width is programmed as a code `p`, and the line holds 16·(p+1) pixels. The number of panel clocks this takes depends on the panel type, because STN panels shift several pixels per clock.

Top module: `lcd_hline_timer`

## Requirements
- R1: After reset, each line runs through sync, back porch, active, front porch and line-end, in that order. The next line's sync follows the line-end strobe directly.
- R2: The active window lasts CPL panel clocks. With p the width code and pixel count 16·(p+1), CPL is set by `cfg_panel`: 0 (TFT) gives 16·(p+1), 1 (4-bit mono STN) gives 4·(p+1), 2 (8-bit mono STN) gives 2·(p+1), and 3 (colour STN, 8 pixels per 3 clocks) gives 6·(p+1). The `cpl` output holds the CPL of the line in progress.
- R3: One panel clock period is `cfg_pcd`+2 system clocks. The non-inverted clock is low for floor(N/2) cycles and then high. It restarts low at the start of sync, and the active window holds exactly CPL rising edges.
- R4: Sync width and back porch each last max(code, 2) panel clocks. The front porch lasts max(code, 1) panel clocks.
- R5: The line-end strobe is high for exactly 4 system clocks, directly after the front porch. The panel clock is held at its idle level during the strobe.
- R6: Configuration inputs are sampled only on the clock edge that enters sync. A change made at any later point in a line has no effect on that line.
- R7: When `cfg_inv_hs` is 1, `hsync` is active low. When it is 0, `hsync` is active high.
- R8: `cfg_inv_clk` = 1 inverts `pclk`, and `cfg_inv_oe` = 1 makes `de` active low. Both default to non-inverted at 0.
- R9: `de` is active only in the active window. It asserts in the same cycle as a falling (launch) edge of the non-inverted panel clock.
- R10: During reset, `hsync`, `pclk`, `de`, `line_end` and `cpl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hsw | input | PORCH_W | Sync width, in panel clocks |
| cfg_hbp | input | PORCH_W | Back porch, in panel clocks |
| cfg_hfp | input | PORCH_W | Front porch, in panel clocks |
| cfg_ppl | input | PPL_W | Active width code p (16·(p+1) pixels) |
| cfg_pcd | input | PCD_W | Panel clock divisor code |
| cfg_panel | input | 2 | Panel type: 0 TFT, 1 mono 4-bit, 2 mono 8-bit, 3 colour STN |
| cfg_inv_hs | input | 1 | Makes sync active low |
| cfg_inv_clk | input | 1 | Inverts the panel clock |
| cfg_inv_oe | input | 1 | Makes data-enable active low |
| hsync | output | 1 | Horizontal sync |
| pclk | output | 1 | Panel clock |
| de | output | 1 | Data-enable window |
| cpl | output | PPL_W+5 | Panel clocks in the active window |
| line_end | output | 1 | Line-end strobe |

## Verification
Every output is decoded from registers with no further stage. An output therefore changes in the system-clock cycle that follows the edge moving the state or the divider counter. The configuration takes effect from the first cycle of sync. The bench samples at the falling clock edge and measures each region as the number of samples in which its output is active. It compares these counts with widths computed from the clamped codes multiplied by `cfg_pcd`+2. The bench loads the next line's configuration as soon as it sees a sync begin, so the values change in the middle of a line by design. The measured line is still checked against the values that were on the inputs before that sync.

// File: rtl/lht_pkg.sv
package lht_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_BPORCH,
        ST_ACTIVE,
        ST_FPORCH,
        ST_LEND
    } lht_state_t;

    typedef enum logic [1:0] {
        PNL_TFT   = 2'd0,
        PNL_MONO4 = 2'd1,
        PNL_MONO8 = 2'd2,
        PNL_CSTN  = 2'd3
    } lht_panel_t;
endpackage

// File: rtl/lht_pclk_div.sv
module lht_pclk_div #(
    parameter int PCD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PCD_W-1:0] pcd,
    output logic             tick,
    output logic             pclk_raw
);
    localparam int DW = PCD_W + 1;

    logic [DW-1:0] cnt;
    logic [DW-1:0] period;

    assign period   = {1'b0, pcd} + DW'(2);
    assign tick     = run && (cnt == period - DW'(1));
    assign pclk_raw = run && (cnt >= (period >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + DW'(1);
    end

    // R3: the phase counter stays inside one panel-clock period
    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period);
    // R5: the divider sits at phase zero once the line stops
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/lht_cpl_calc.sv
module lht_cpl_calc import lht_pkg::*; #(
    parameter int PPL_W = 6,
    parameter int CPL_W = PPL_W + 5
) (
    input  logic [PPL_W-1:0] ppl,
    input  lht_panel_t       panel,
    output logic [CPL_W-1:0] cpl
);
    logic [CPL_W-1:0] pix;

    assign pix = (CPL_W'(ppl) + CPL_W'(1)) << 4;

    always_comb begin
        unique case (panel)
            PNL_TFT:   cpl = pix;
            PNL_MONO4: cpl = pix >> 2;
            PNL_MONO8: cpl = pix >> 3;
            PNL_CSTN:  cpl = (pix >> 3) * CPL_W'(3);
            default:   cpl = pix;
        endcase
    end
endmodule

// File: rtl/lcd_hline_timer.sv
module lcd_hline_timer import lht_pkg::*; #(
    parameter int PORCH_W = 8,
    parameter int PPL_W   = 6,
    parameter int PCD_W   = 5,
    parameter int LE_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORCH_W-1:0] cfg_hsw,
    input  logic [PORCH_W-1:0] cfg_hbp,
    input  logic [PORCH_W-1:0] cfg_hfp,
    input  logic [PPL_W-1:0]   cfg_ppl,
    input  logic [PCD_W-1:0]   cfg_pcd,
    input  logic [1:0]         cfg_panel,
    input  logic               cfg_inv_hs,
    input  logic               cfg_inv_clk,
    input  logic               cfg_inv_oe,
    output logic               hsync,
    output logic               pclk,
    output logic               de,
    output logic [PPL_W+4:0]   cpl,
    output logic               line_end
);
    localparam int CPL_W = PPL_W + 5;
    localparam int CNT_W = (CPL_W > PORCH_W) ? CPL_W : PORCH_W;
    localparam int LE_W  = $clog2(LE_CYC + 1);

    lht_state_t state, nxt;

    logic [CNT_W-1:0]   rcnt;
    logic [LE_W-1:0]    le_cnt;
    logic [PORCH_W-1:0] hsw_c, hbp_c, hfp_c;
    logic [PORCH_W-1:0] hbp_l, hfp_l;
    logic [PCD_W-1:0]   pcd_l;
    logic [CPL_W-1:0]   cpl_c, cpl_l;
    logic               inv_hs_l, inv_clk_l, inv_oe_l;
    logic               run, tick, pclk_raw, rdone, le_done, load;

    // R4: clamp short widths to the legal minimum
    assign hsw_c = (cfg_hsw < PORCH_W'(2)) ? PORCH_W'(2) : cfg_hsw;
    assign hbp_c = (cfg_hbp < PORCH_W'(2)) ? PORCH_W'(2) : cfg_hbp;
    assign hfp_c = (cfg_hfp < PORCH_W'(1)) ? PORCH_W'(1) : cfg_hfp;

    assign run     = (state == ST_SYNC) || (state == ST_BPORCH) ||
                     (state == ST_ACTIVE) || (state == ST_FPORCH);
    assign rdone   = tick && (rcnt == '0);
    assign le_done = (le_cnt == LE_W'(LE_CYC - 1));
    assign load    = (state == ST_IDLE) || ((state == ST_LEND) && le_done);

    lht_cpl_calc #(.PPL_W(PPL_W), .CPL_W(CPL_W)) u_cpl (
        .ppl   (cfg_ppl),
        .panel (lht_panel_t'(cfg_panel)),
        .cpl   (cpl_c)
    );

    lht_pclk_div #(.PCD_W(PCD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pcd      (pcd_l),
        .tick     (tick),
        .pclk_raw (pclk_raw)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions (R1)
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = ST_SYNC;
            ST_SYNC:   if (rdone)   nxt = ST_BPORCH;
            ST_BPORCH: if (rdone)   nxt = ST_ACTIVE;
            ST_ACTIVE: if (rdone)   nxt = ST_FPORCH;
            ST_FPORCH: if (rdone)   nxt = ST_LEND;
            ST_LEND:   if (le_done) nxt = ST_SYNC;
            default:   nxt = ST_IDLE;
        endcase
    end

    // region counter and per-line configuration (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt      <= '0;
            le_cnt    <= '0;
            hbp_l     <= '0;
            hfp_l     <= '0;
            pcd_l     <= '0;
            cpl_l     <= '0;
            inv_hs_l  <= 1'b0;
            inv_clk_l <= 1'b0;
            inv_oe_l  <= 1'b0;
        end else if (load) begin
            rcnt      <= CNT_W'(hsw_c) - CNT_W'(1);
            le_cnt    <= '0;
            hbp_l     <= hbp_c;
            hfp_l     <= hfp_c;
            pcd_l     <= cfg_pcd;
            cpl_l     <= cpl_c;
            inv_hs_l  <= cfg_inv_hs;
            inv_clk_l <= cfg_inv_clk;
            inv_oe_l  <= cfg_inv_oe;
        end else if (state == ST_LEND) begin
            le_cnt <= le_cnt + LE_W'(1);
        end else if (rdone) begin
            le_cnt <= '0;
            unique case (state)
                ST_SYNC:   rcnt <= CNT_W'(hbp_l) - CNT_W'(1);
                ST_BPORCH: rcnt <= CNT_W'(cpl_l) - CNT_W'(1);
                ST_ACTIVE: rcnt <= CNT_W'(hfp_l) - CNT_W'(1);
                default:   rcnt <= '0;
            endcase
        end else if (tick) begin
            rcnt <= rcnt - CNT_W'(1);
        end
    end

    // outputs (R7, R8, R9)
    always_comb begin
        hsync    = (state == ST_SYNC) ^ inv_hs_l;
        de       = (state == ST_ACTIVE) ^ inv_oe_l;
        pclk     = pclk_raw ^ inv_clk_l;
        line_end = (state == ST_LEND);
        cpl      = cpl_l;
    end

    // R1: sync is always followed by the back porch
    p_sync_then_bp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && nxt != ST_SYNC) |=> (state == ST_BPORCH));
    // R1: the front porch always ends in the line-end strobe
    p_fp_then_lend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FPORCH && nxt != ST_FPORCH) |=> (state == ST_LEND));
    // R4: every sync region is loaded with at least two panel clocks
    p_sync_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SYNC) |-> (rcnt >= CNT_W'(1)));
    // R6: settings stay fixed while a line is running
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(cpl_l) && $stable(pcd_l) && $stable(inv_hs_l)));
    // R5: the strobe count starts from zero on entry
    p_lend_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_LEND) |-> (le_cnt == '0));
    // R9: data-enable opens at phase zero of the panel clock
    p_de_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_ACTIVE) |-> !pclk_raw);
endmodule

// File: tb/lcd_hline_timer_tb.sv
module lcd_hline_timer_tb;
    typedef struct {
        int hsw; int hbp; int hfp; int ppl; int pcd; int panel;
        bit ih; bit ic; bit io;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_hsw, cfg_hbp, cfg_hfp;
    logic [5:0]  cfg_ppl;
    logic [4:0]  cfg_pcd;
    logic [1:0]  cfg_panel;
    logic        cfg_inv_hs, cfg_inv_clk, cfg_inv_oe;
    logic        hsync, pclk, de, line_end;
    logic [10:0] cpl;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lcd_hline_timer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp),
        .cfg_ppl(cfg_ppl), .cfg_pcd(cfg_pcd), .cfg_panel(cfg_panel),
        .cfg_inv_hs(cfg_inv_hs), .cfg_inv_clk(cfg_inv_clk), .cfg_inv_oe(cfg_inv_oe),
        .hsync(hsync), .pclk(pclk), .de(de), .cpl(cpl), .line_end(line_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cpl(cfg_t c);
        int pix = 16 * (c.ppl + 1);
        case (c.panel)
            0: return pix;
            1: return pix / 4;
            2: return pix / 8;
            default: return (pix / 8) * 3;
        endcase
    endfunction

    function automatic int atleast(int v, int m);
        return (v < m) ? m : v;
    endfunction

    task automatic apply(cfg_t c);
        cfg_hsw = 8'(c.hsw); cfg_hbp = 8'(c.hbp); cfg_hfp = 8'(c.hfp);
        cfg_ppl = 6'(c.ppl); cfg_pcd = 5'(c.pcd); cfg_panel = 2'(c.panel);
        cfg_inv_hs = c.ih; cfg_inv_clk = c.ic; cfg_inv_oe = c.io;
    endtask

    function automatic cfg_t pick(int i);
        cfg_t c;
        case (i)
            0: c = '{3, 5, 5, 0, 1, 0, 1'b0, 1'b0, 1'b0};
            1: c = '{0, 1, 0, 1, 0, 1, 1'b1, 1'b0, 1'b0};
            2: c = '{2, 2, 1, 2, 5, 3, 1'b0, 1'b1, 1'b1};
            3: c = '{1, 0, 3, 0, 31, 2, 1'b1, 1'b1, 1'b1};
            4: c = '{255, 255, 255, 63, 0, 0, 1'b0, 1'b0, 1'b0};
            default: c = '{int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                          int'($urandom_range(0, 12)), int'($urandom_range(0, 7)),
                          int'($urandom_range(0, 6)), int'($urandom_range(0, 3)),
                          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                          1'($urandom_range(0, 1))};
        endcase
        return c;
    endfunction

    task automatic measure(cfg_t cur, cfg_t nxt);
        int n = cur.pcd + 2;
        int s = 0, b = 0, a = 0, f = 0, l = 0, rises = 0, lbad = 0;
        bit prev;
        chk("R3 R8 pclk idle level at sync start", int'(pclk), int'(cur.ic));
        chk("R2 cpl output", int'(cpl), exp_cpl(cur));
        while (hsync ^ cur.ih) begin s++; @(negedge clk); end
        chk("R4 R6 R7 sync width", s, atleast(cur.hsw, 2) * n);
        while (!(de ^ cur.io) && !(hsync ^ cur.ih) && !line_end) begin b++; @(negedge clk); end
        chk("R4 back porch width", b, atleast(cur.hbp, 2) * n);
        chk("R1 active follows back porch", int'(de ^ cur.io), 1);
        chk("R9 de opens on launch edge", int'(pclk ^ cur.ic), 0);
        prev = pclk ^ cur.ic;
        while (de ^ cur.io) begin
            if ((pclk ^ cur.ic) && !prev) rises++;
            prev = pclk ^ cur.ic;
            a++;
            @(negedge clk);
        end
        chk("R2 R8 active width", a, exp_cpl(cur) * n);
        chk("R3 panel clock edges in active", rises, exp_cpl(cur));
        while (!line_end && !(hsync ^ cur.ih) && !(de ^ cur.io)) begin f++; @(negedge clk); end
        chk("R4 front porch width", f, atleast(cur.hfp, 1) * n);
        chk("R1 line-end follows front porch", int'(line_end), 1);
        while (line_end) begin
            if (pclk != cur.ic) lbad++;
            l++;
            @(negedge clk);
        end
        chk("R5 line-end width", l, 4);
        chk("R5 panel clock held during line-end", lbad, 0);
        chk("R1 R7 next sync follows line-end", int'(hsync ^ nxt.ih), 1);
    endtask

    initial begin
        cfg_t cur, nxt;
        void'($urandom(32'd20240));
        cur = pick(0);
        apply(cur);
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", int'({hsync, pclk, de, line_end, cpl}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        while (!(hsync ^ cur.ih)) @(negedge clk);
        for (int i = 1; i <= 30; i++) begin
            nxt = pick(i);
            apply(nxt);
            measure(cur, nxt);
            cur = nxt;
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule